// File: doc/BRIEF.md
# Table-and-Series Sine/Cosine Rotator

This block returns both the sine and the cosine of pi times a reduced angle that lies in the first eighth of a turn, [0, 1/4). It accepts one new angle on every clock and delivers both results a fixed number of cycles later. It is meant to sit behind an octant-folding stage that maps a full-circle phase into this range, and in front of whatever swaps or negates the two results to rebuild the original quadrant.

The upper bits of the angle select a coarse point whose sine and cosine are held in a constant table. The table is computed at elaboration and pre-scaled by (1 - 2^-W), so that a full-scale value of one never overflows. The lower bits are scaled by pi into a small residual angle z. Short series give z^2/2 and z - z^3/6. The coarse pair is then rotated by z with two corrections per output, each formed as the table value times z^2/2 and as the other table value times sin z. The product with cos z itself is never formed. Internal values carry four guard bits. Each output is rounded to nearest and clamped to the unsigned W-bit range.

Top module: `sincos_rotator`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly 5 rising clock edges, and the results presented with it belong to the angle accepted with that `in_valid`.
- R2: The angle is y = `in_angle` * 2^-W, with `in_angle` an unsigned (W-2)-bit integer. `out_sin` is an unsigned fraction with weight 2^-W per LSB, and it differs from 2^W * (1 - 2^-W) * sin(pi*y) by strictly less than 1.
- R3: With the same encodings, `out_cos` differs from 2^W * (1 - 2^-W) * cos(pi*y) by strictly less than 1.
- R4: For `in_angle` = 0, `out_sin` is exactly 0 and `out_cos` is exactly 2^W - 1 (all ones).
- R5: For every angle in range, `out_sin` is strictly less than `out_cos`.
- R6: While `rst_n` is low, `out_valid` is low. Results in flight when reset is asserted never appear at the output.
- R7: An angle is accepted on every cycle that `in_valid` is high. The number of results delivered equals the number of angles accepted, and the data outputs are never unknown when `out_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Angle on `in_angle` is to be processed this cycle |
| in_angle | input | W-2 | Reduced angle, value `in_angle` * 2^-W in [0, 1/4) |
| out_valid | output | 1 | Results on `out_sin` and `out_cos` are valid |
| out_sin | output | W | Scaled sin(pi*y), unsigned, LSB weight 2^-W |
| out_cos | output | W | Scaled cos(pi*y), unsigned, LSB weight 2^-W |

## Verification
The bench sweeps every angle back to back, so every coarse table segment and both of its edges are covered. A wrong split between table index and residual would show as error jumps at segment boundaries, and a dropped guard bit or a wrongly signed correction would push some results past one unit of error. Angle zero is aimed at directly: an unscaled table would wrap the cosine to zero there. The top of the range, where sine and cosine are only about four units apart, catches a swapped or sign-flipped rotation term. A reset with results still in the pipe, followed by a sparse valid pattern, exposes valid bits that drift out of step with their data or that survive a flush.

// File: rtl/sc_pkg.sv
package sc_pkg;

    // Number of register stages from in_angle to the outputs.
    localparam int SC_STAGES = 5;

    localparam real SC_PI = 3.14159265358979323846;

    // Elaboration-time series used only to fill the constant table.
    function automatic real sc_sin_series(input real x);
        real term;
        real acc;
        term = x;
        acc  = x;
        for (int k = 1; k < 12; k++) begin
            term = -term * x * x / (real'(2 * k) * real'(2 * k + 1));
            acc  = acc + term;
        end
        return acc;
    endfunction

    function automatic real sc_cos_series(input real x);
        real term;
        real acc;
        term = 1.0;
        acc  = 1.0;
        for (int k = 1; k < 12; k++) begin
            term = -term * x * x / (real'(2 * k - 1) * real'(2 * k));
            acc  = acc + term;
        end
        return acc;
    endfunction

endpackage

// File: rtl/sc_rom.sv
// Coarse-angle table: entry i holds (1 - 2^-W) * {sin,cos}(pi * i / 2^(A+2)),
// rounded to F fractional bits.
module sc_rom #(
    parameter int A = 4,
    parameter int W = 16,
    parameter int F = 20
) (
    input  logic [A-1:0] idx,
    output logic [F-1:0] s_val,
    output logic [F-1:0] c_val
);
    import sc_pkg::*;

    localparam int TD = 2 ** A;

    typedef logic [TD-1:0][F-1:0] tab_t;

    function automatic tab_t build_tab(input bit want_cos);
        tab_t tab;
        real  ang;
        real  v;
        for (int i = 0; i < TD; i++) begin
            ang = SC_PI * real'(i) / real'(4 * TD);
            v   = want_cos ? sc_cos_series(ang) : sc_sin_series(ang);
            v   = v * (1.0 - 2.0 ** (-W));
            tab[i] = F'($rtoi(v * (2.0 ** F) + 0.5));
        end
        return tab;
    endfunction

    localparam tab_t SIN_TAB = build_tab(1'b0);
    localparam tab_t COS_TAB = build_tab(1'b1);

    assign s_val = SIN_TAB[idx];
    assign c_val = COS_TAB[idx];

endmodule

// File: rtl/sc_taylor.sv
// Residual-angle series: z^2/2 through a squarer, sin z = z - z^3/6 with
// z^3/6 formed as (z^2/2 * z) / 3. All values in units of 2^-F.
module sc_taylor #(
    parameter int F = 20,
    parameter int A = 4
) (
    input  logic [F-A-1:0]     z,
    output logic [F-2*A-2:0]   z2h,
    output logic [F-A-1:0]     sinz
);
    localparam int ZW  = F - A;          // z < 2^-A
    localparam int Z2W = F - 2 * A - 1;  // z^2/2 < 2^-(2A+1)
    localparam int ZCW = F - 3 * A - 1;  // z^3/2 < 2^-(3A+1)
    localparam int Z3W = F - 3 * A - 2;  // z^3/6 fits one bit less

    logic [2*ZW-1:0]   sq;
    logic [Z2W+ZW-1:0] cu;
    logic [ZCW-1:0]    zc;
    logic [Z3W-1:0]    z3;

    always_comb begin
        sq   = (2 * ZW)'(z) * (2 * ZW)'(z);
        z2h  = Z2W'(sq >> (F + 1));
        cu   = (Z2W + ZW)'(z2h) * (Z2W + ZW)'(z);
        zc   = ZCW'(cu >> F);
        z3   = Z3W'(zc / ZCW'(3));
        sinz = z - ZW'(z3);
    end

endmodule

// File: rtl/sc_rotate.sv
// The four correction products, each truncated to 2^-F.
module sc_rotate #(
    parameter int F = 20,
    parameter int A = 4
) (
    input  logic [F-1:0]       s_tab,
    input  logic [F-1:0]       c_tab,
    input  logic [F-2*A-2:0]   z2h,
    input  logic [F-A-1:0]     sinz,
    output logic [F-2*A-2:0]   s_by_h,
    output logic [F-2*A-2:0]   c_by_h,
    output logic [F-A-1:0]     c_by_sz,
    output logic [F-A-1:0]     s_by_sz
);
    localparam int ZW  = F - A;
    localparam int Z2W = F - 2 * A - 1;

    logic [F+Z2W-1:0] ph_s;
    logic [F+Z2W-1:0] ph_c;
    logic [F+ZW-1:0]  pz_c;
    logic [F+ZW-1:0]  pz_s;

    always_comb begin
        ph_s    = (F + Z2W)'(s_tab) * (F + Z2W)'(z2h);
        ph_c    = (F + Z2W)'(c_tab) * (F + Z2W)'(z2h);
        pz_c    = (F + ZW)'(c_tab) * (F + ZW)'(sinz);
        pz_s    = (F + ZW)'(s_tab) * (F + ZW)'(sinz);
        s_by_h  = Z2W'(ph_s >> F);
        c_by_h  = Z2W'(ph_c >> F);
        c_by_sz = ZW'(pz_c >> F);
        s_by_sz = ZW'(pz_s >> F);
    end

endmodule

// File: rtl/sincos_rotator.sv
// Five-stage sine/cosine of pi*y for y in [0, 1/4):
//   1 table read, 2 residual z = pi*y_low, 3 series terms,
//   4 correction products, 5 combine, round and clamp.
module sincos_rotator #(
    parameter int W = 16,
    parameter int G = 4,
    parameter int A = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [W-3:0]   in_angle,
    output logic           out_valid,
    output logic [W-1:0]   out_sin,
    output logic [W-1:0]   out_cos
);
    import sc_pkg::*;

    localparam int F   = W + G;          // internal fraction bits
    localparam int IW  = W - 2;          // angle width
    localparam int RW  = IW - A;         // residual angle bits
    localparam int ZW  = F - A;
    localparam int Z2W = F - 2 * A - 1;
    localparam int PB  = F + 2;          // fraction bits of the pi constant
    localparam int PW  = RW + PB + 2;    // width of the pi product
    localparam int ZSH = W + PB - F;     // shift that lands z on 2^-F
    localparam int AW  = F + 2;          // signed accumulator width

    localparam logic [PB+1:0] PIK = (PB + 2)'($rtoi(SC_PI * (2.0 ** PB) + 0.5));
    localparam logic signed [AW-1:0] HALF = AW'(2 ** (G - 1));

    typedef struct packed {
        // stage 1: table read
        logic           v1;
        logic [F-1:0]   s1;
        logic [F-1:0]   c1;
        logic [RW-1:0]  r1;
        // stage 2: residual angle
        logic           v2;
        logic [F-1:0]   s2;
        logic [F-1:0]   c2;
        logic [ZW-1:0]  z2;
        // stage 3: series terms
        logic           v3;
        logic [F-1:0]   s3;
        logic [F-1:0]   c3;
        logic [Z2W-1:0] h3;
        logic [ZW-1:0]  n3;
        // stage 4: correction products
        logic           v4;
        logic [F-1:0]   s4;
        logic [F-1:0]   c4;
        logic [Z2W-1:0] sh4;
        logic [Z2W-1:0] ch4;
        logic [ZW-1:0]  cn4;
        logic [ZW-1:0]  sn4;
        // stage 5: results
        logic           v5;
        logic [W-1:0]   so5;
        logic [W-1:0]   co5;
    } pipe_t;

    pipe_t pipe_d;
    pipe_t pipe_q;

    logic [F-1:0]   rom_s;
    logic [F-1:0]   rom_c;
    logic [PW-1:0]  zprod;
    logic [Z2W-1:0] tay_h;
    logic [ZW-1:0]  tay_n;
    logic [Z2W-1:0] rot_sh;
    logic [Z2W-1:0] rot_ch;
    logic [ZW-1:0]  rot_cn;
    logic [ZW-1:0]  rot_sn;
    logic signed [AW-1:0] sin_acc;
    logic signed [AW-1:0] cos_acc;

    sc_rom #(.A(A), .W(W), .F(F)) u_rom (
        .idx   (in_angle[IW-1 -: A]),
        .s_val (rom_s),
        .c_val (rom_c)
    );

    assign zprod = PW'(pipe_q.r1) * PW'(PIK);

    sc_taylor #(.F(F), .A(A)) u_taylor (
        .z    (pipe_q.z2),
        .z2h  (tay_h),
        .sinz (tay_n)
    );

    sc_rotate #(.F(F), .A(A)) u_rotate (
        .s_tab   (pipe_q.s3),
        .c_tab   (pipe_q.c3),
        .z2h     (pipe_q.h3),
        .sinz    (pipe_q.n3),
        .s_by_h  (rot_sh),
        .c_by_h  (rot_ch),
        .c_by_sz (rot_cn),
        .s_by_sz (rot_sn)
    );

    // Round half up by dropping G guard bits, clamp to [0, 2^W - 1].
    function automatic logic [W-1:0] round_out(input logic signed [AW-1:0] acc);
        logic signed [AW-1:0] shifted;
        shifted = acc >>> G;
        if (acc < 0) begin
            return '0;
        end else if (shifted > AW'((2 ** W) - 1)) begin
            return '1;
        end else begin
            return W'(shifted);
        end
    endfunction

    always_comb begin
        sin_acc = signed'(AW'(pipe_q.s4)) - signed'(AW'(pipe_q.sh4))
                + signed'(AW'(pipe_q.cn4)) + HALF;
        cos_acc = signed'(AW'(pipe_q.c4)) - signed'(AW'(pipe_q.ch4))
                - signed'(AW'(pipe_q.sn4)) + HALF;
    end

    always_comb begin
        pipe_d = pipe_q;

        pipe_d.v1  = in_valid;
        pipe_d.s1  = rom_s;
        pipe_d.c1  = rom_c;
        pipe_d.r1  = in_angle[RW-1:0];

        pipe_d.v2  = pipe_q.v1;
        pipe_d.s2  = pipe_q.s1;
        pipe_d.c2  = pipe_q.c1;
        pipe_d.z2  = ZW'(zprod >> ZSH);

        pipe_d.v3  = pipe_q.v2;
        pipe_d.s3  = pipe_q.s2;
        pipe_d.c3  = pipe_q.c2;
        pipe_d.h3  = tay_h;
        pipe_d.n3  = tay_n;

        pipe_d.v4  = pipe_q.v3;
        pipe_d.s4  = pipe_q.s3;
        pipe_d.c4  = pipe_q.c3;
        pipe_d.sh4 = rot_sh;
        pipe_d.ch4 = rot_ch;
        pipe_d.cn4 = rot_cn;
        pipe_d.sn4 = rot_sn;

        pipe_d.v5  = pipe_q.v4;
        pipe_d.so5 = round_out(sin_acc);
        pipe_d.co5 = round_out(cos_acc);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign out_valid = pipe_q.v5;
    assign out_sin   = pipe_q.so5;
    assign out_cos   = pipe_q.co5;

endmodule

// File: rtl/sc_rotator_chk.sv
module sc_rotator_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [W-3:0] in_angle,
    input logic         out_valid,
    input logic [W-1:0] out_sin,
    input logic [W-1:0] out_cos
);
    // Edges seen since reset, saturating; guards the $past window.
    logic [2:0] cyc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q <= '0;
        end else if (cyc_q != 3'd7) begin
            cyc_q <= cyc_q + 3'd1;
        end
    end

    assert_valid_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q >= 3'd5) |-> (out_valid == $past(in_valid, 5)));

    assert_zero_angle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q >= 3'd5 && out_valid && $past(in_valid, 5) && $past(in_angle, 5) == '0)
        |-> (out_sin == '0 && out_cos == '1));

    assert_sin_below_cos_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_sin < out_cos));

    assert_reset_flush_R6: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    assert_known_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !$isunknown({out_sin, out_cos}));

endmodule

bind sincos_rotator sc_rotator_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_angle  (in_angle),
    .out_valid (out_valid),
    .out_sin   (out_sin),
    .out_cos   (out_cos)
);

// File: tb/sincos_rotator_bench.sv
module sincos_rotator_bench;

    localparam int  W   = 16;
    localparam int  IW  = W - 2;
    localparam int  N   = 1 << IW;
    localparam int  LAT = 5;
    localparam real PI  = 3.14159265358979323846;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [IW-1:0] in_angle = '0;
    logic          out_valid;
    logic [W-1:0]  out_sin;
    logic [W-1:0]  out_cos;

    int n_chk  = 0;
    int n_fail = 0;
    int n_sent = 0;
    int n_got  = 0;
    bit done   = 1'b0;
    bit live   = 1'b0;
    bit vd [LAT];
    int ad [LAT];

    sincos_rotator u_sincos_rotator (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_angle  (in_angle),
        .out_valid (out_valid),
        .out_sin   (out_sin),
        .out_cos   (out_cos)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input bit ok, input real act, input real exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0f expected=%0f", req, act, exp);
        end
    endtask

    function automatic real absr(input real x);
        return (x < 0.0) ? -x : x;
    endfunction

    // Reference delay line: angles and valids as sampled by the design.
    always @(posedge clk) begin
        if (!rst_n) begin
            live = 1'b0;
            for (int i = 0; i < LAT; i++) begin
                vd[i] = 1'b0;
                ad[i] = 0;
            end
        end else begin
            live = 1'b1;
            for (int i = LAT - 1; i > 0; i--) begin
                vd[i] = vd[i-1];
                ad[i] = ad[i-1];
            end
            vd[0] = in_valid;
            ad[0] = int'(in_angle);
        end
    end

    // Per-cycle comparison against the real-valued model.
    always @(negedge clk) begin
        if (live && !done) begin
            check("R1 valid timing", out_valid == vd[LAT-1], real'(out_valid), real'(vd[LAT-1]));
            if (out_valid && vd[LAT-1]) begin
                real y;
                real es;
                real ec;
                n_got++;
                y  = real'(ad[LAT-1]) / (2.0 ** W);
                es = (1.0 - 2.0 ** (-W)) * $sin(PI * y) * (2.0 ** W);
                ec = (1.0 - 2.0 ** (-W)) * $cos(PI * y) * (2.0 ** W);
                check("R2 sine error below 1 ulp", absr(real'(out_sin) - es) < 1.0, real'(out_sin), es);
                check("R3 cosine error below 1 ulp", absr(real'(out_cos) - ec) < 1.0, real'(out_cos), ec);
                check("R5 sine below cosine", out_sin < out_cos, real'(out_sin), real'(out_cos));
                if (ad[LAT-1] == 0) begin
                    check("R4 zero angle sine", out_sin == '0, real'(out_sin), 0.0);
                    check("R4 zero angle cosine", out_cos == '1, real'(out_cos), (2.0 ** W) - 1.0);
                end
            end
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=expired expected=completion");
            finish_run();
        end
    end

    initial begin
        // R6: idle while reset is held
        repeat (3) begin
            @(negedge clk);
            check("R6 idle in reset", out_valid == 1'b0, real'(out_valid), 0.0);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R6: results in flight are discarded by a reset
        for (int k = 1; k <= 3; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_angle = IW'(k * 1000);
        end
        @(negedge clk);
        in_valid = 1'b0;
        #2 rst_n = 1'b0;
        @(negedge clk);
        check("R6 flush on reset", out_valid == 1'b0, real'(out_valid), 0.0);
        @(negedge clk);
        check("R6 still idle", out_valid == 1'b0, real'(out_valid), 0.0);
        rst_n = 1'b1;
        repeat (8) @(negedge clk);
        n_sent = 0;
        n_got  = 0;

        // R2 R3 R7: every angle, one per cycle
        for (int a = 0; a < N; a++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_angle = IW'(a);
            n_sent++;
        end

        // R1: sparse valids with scattered angles, top of range first
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            in_valid = (k % 3 == 0);
            in_angle = IW'(N - 1 - ((k * 53) % N));
            if (k % 3 == 0) n_sent++;
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (LAT + 3) @(negedge clk);

        done = 1'b1;
        check("R7 results equal accepted inputs", n_got == n_sent, real'(n_got), real'(n_sent));
        finish_run();
    end

endmodule